// File: doc/BRIEF.md
# On-Chip Scan Response Checker

This block judges scan test results inside the chip. A packetized test bus delivers one word per shift cycle, carrying, for every scan channel, the value the response should have and a care bit that says whether that channel counts in this cycle. The actual scan-out bits from the internal chains arrive on a separate input, aligned to the same handshake. The block compares them locally, so no external tester is needed.

The raw scan-out data never leaves the block. Only a summary is kept, in a small status store that sits outside the functional logic: a sticky fail flag, a saturating mismatch counter and a sticky mask of the channels that failed. Test-network software reads this summary through a narrow register port. The same port takes a keyed write that clears the summary between test runs. While that clear is in progress, the block applies back-pressure on the packet input, and no word is dropped.

Top module: `scan_resp_checker`

## Requirements
- R1: A channel takes part in the comparison only when its care bit is 1. A difference between expected and actual data on a channel whose care bit is 0 has no effect on any summary value.
- R2: A word is compared only in a cycle where `pkt_valid` and `pkt_ready` are both high. Data presented while `pkt_valid` is low has no effect.
- R3: Status register (address 0) bit 0 is the fail flag. It sets when a compared word has at least one unmasked mismatch, and it then stays set through later passing words until a clear.
- R4: The counter (address 1) rises by exactly one for each compared word that has one or more unmasked mismatches, whatever the number of mismatching channels in that word.
- R5: The counter saturates at 2^16-1 and holds there. Status bit 1 reads 1 while the counter is saturated.
- R6: The lane register (address 2) holds the OR, over all compared words since the last clear, of the per-channel unmasked mismatches. Bit i stands for channel i.
- R7: A write to address 3 of the key value 0xA5C3 zeroes the fail flag, the counter and the lane register. It also discards a word accepted in the cycle just before the clear.
- R8: `pkt_ready` is low in the cycle that the clear write is presented. A word held valid across that cycle is accepted in the next cycle and compared.
- R9: After reset, `pkt_ready` is high and the status, counter and lane registers read 0.
- R10: Read data appears on `reg_rdata` one cycle after `reg_rd_en` and holds while no read is issued. Address 3 reads as 0. A result becomes readable from the second clock edge after its handshake.
- R11: A write of any value other than the key, or a write to any address other than 3, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet word valid |
| pkt_ready | output | 1 | Block can accept a word |
| pkt_expect | input | LANES | Expected response per channel |
| pkt_care | input | LANES | Per-channel compare enable |
| scan_resp | input | LANES | Actual scan-out bits, aligned to the packet word |
| reg_addr | input | 2 | Register address |
| reg_rd_en | input | 1 | Read strobe |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data (clear key) |
| reg_rdata | output | DATA_W | Registered read data |

## Verification
The assertions assume that a reset comes before any traffic, and that the register port presents a write for a single cycle at a time. The bench never issues a read and a write in the same cycle. The bench drives every input on the falling clock edge and holds a packet word steady until the block takes it. It leaves at least three idle cycles between the last handshake and each read, so that the one-cycle compare stage and the update of the summary have both settled.

// File: rtl/scmp_pkg.sv
package scmp_pkg;
  typedef enum logic [1:0] {
    ADR_STAT = 2'd0,
    ADR_CNT  = 2'd1,
    ADR_LANE = 2'd2,
    ADR_CTRL = 2'd3
  } scmp_addr_e;

  localparam int STAT_FAIL_BIT = 0;
  localparam int STAT_SAT_BIT  = 1;
endpackage

// File: rtl/scmp_lane_cmp.sv
module scmp_lane_cmp #(
  parameter int LANES = 16
) (
  input  logic [LANES-1:0] expect_i,
  input  logic [LANES-1:0] care_i,
  input  logic [LANES-1:0] resp_i,
  output logic [LANES-1:0] miss_vec_o,
  output logic             any_miss_o
);
  // one comparator per scan channel
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign miss_vec_o[g] = care_i[g] & (expect_i[g] ^ resp_i[g]);
  end

  assign any_miss_o = |miss_vec_o;
endmodule

// File: rtl/scmp_accum.sv
module scmp_accum #(
  parameter int LANES = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             clr_i,
  input  logic [LANES-1:0] miss_vec_i,
  input  logic             any_miss_i,
  output logic             s1_vld_o,
  output logic             fail_o,
  output logic             sat_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [LANES-1:0] lanes_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // compare stage
  logic             s1_vld_q, s1_vld_d;
  logic             s1_any_q;
  logic [LANES-1:0] s1_vec_q;
  // summary store
  logic             fail_q, fail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LANES-1:0] lanes_q, lanes_d;
  logic             upd_en;

  always_comb begin
    s1_vld_d = take_i & ~clr_i;
    upd_en   = s1_vld_q & s1_any_q;
    fail_d   = fail_q;
    cnt_d    = cnt_q;
    lanes_d  = lanes_q;
    if (clr_i) begin
      fail_d  = 1'b0;
      cnt_d   = '0;
      lanes_d = '0;
    end else if (upd_en) begin
      fail_d  = 1'b1;
      lanes_d = lanes_q | s1_vec_q;
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s1_any_q <= 1'b0;
      s1_vec_q <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      if (take_i) begin
        s1_any_q <= any_miss_i;
        s1_vec_q <= miss_vec_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q  <= 1'b0;
      cnt_q   <= '0;
      lanes_q <= '0;
    end else if (clr_i || upd_en) begin
      fail_q  <= fail_d;
      cnt_q   <= cnt_d;
      lanes_q <= lanes_d;
    end
  end

  assign s1_vld_o = s1_vld_q;
  assign fail_o   = fail_q;
  assign sat_o    = (cnt_q == CNT_MAX);
  assign cnt_o    = cnt_q;
  assign lanes_o  = lanes_q;
endmodule

// File: rtl/scmp_regport.sv
module scmp_regport
  import scmp_pkg::*;
#(
  parameter int          LANES   = 16,
  parameter int          CNT_W   = 16,
  parameter int          DATA_W  = 16,
  parameter logic [15:0] CLR_KEY = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fail_i,
  input  logic              sat_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [LANES-1:0]  lanes_i,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] KEY_W = DATA_W'(CLR_KEY);

  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] stat_word;

  always_comb begin
    stat_word                = '0;
    stat_word[STAT_FAIL_BIT] = fail_i;
    stat_word[STAT_SAT_BIT]  = sat_i;
  end

  assign clr_o = wr_en_i && (scmp_addr_e'(addr_i) == ADR_CTRL) && (wdata_i == KEY_W);

  always_comb begin
    case (scmp_addr_e'(addr_i))
      ADR_STAT: rdata_d = stat_word;
      ADR_CNT:  rdata_d = DATA_W'(cnt_i);
      ADR_LANE: rdata_d = DATA_W'(lanes_i);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/scan_resp_checker.sv
module scan_resp_checker #(
  parameter int LANES  = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [LANES-1:0]  pkt_expect,
  input  logic [LANES-1:0]  pkt_care,
  input  logic [LANES-1:0]  scan_resp,
  input  logic [1:0]        reg_addr,
  input  logic              reg_rd_en,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic             take;
  logic             clr_cmd;
  logic [LANES-1:0] miss_vec;
  logic             any_miss;
  logic             s1_vld;
  logic             fail_q;
  logic             sat;
  logic [CNT_W-1:0] cnt_q;
  logic [LANES-1:0] lanes_q;

  // a clear in progress holds off the packet stream
  assign pkt_ready = ~clr_cmd;
  assign take      = pkt_valid & pkt_ready;

  scmp_lane_cmp #(.LANES(LANES)) u_cmp (
    .expect_i   (pkt_expect),
    .care_i     (pkt_care),
    .resp_i     (scan_resp),
    .miss_vec_o (miss_vec),
    .any_miss_o (any_miss)
  );

  scmp_accum #(.LANES(LANES), .CNT_W(CNT_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take),
    .clr_i      (clr_cmd),
    .miss_vec_i (miss_vec),
    .any_miss_i (any_miss),
    .s1_vld_o   (s1_vld),
    .fail_o     (fail_q),
    .sat_o      (sat),
    .cnt_o      (cnt_q),
    .lanes_o    (lanes_q)
  );

  scmp_regport #(.LANES(LANES), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (reg_addr),
    .rd_en_i (reg_rd_en),
    .wr_en_i (reg_wr_en),
    .wdata_i (reg_wdata),
    .fail_i  (fail_q),
    .sat_i   (sat),
    .cnt_i   (cnt_q),
    .lanes_i (lanes_q),
    .clr_o   (clr_cmd),
    .rdata_o (reg_rdata)
  );
endmodule

// File: rtl/scmp_chk.sv
module scmp_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_valid,
  input logic             pkt_ready,
  input logic             clr,
  input logic             s1_vld,
  input logic             fail,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R3
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clr) |=> fail);

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !fail));

  // R5
  cnt_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !clr) |=> (cnt == CMAX));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt == $past(cnt) || cnt == ($past(cnt) + 1'b1)));

  // R4
  cnt_implies_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> fail);

  // R2
  no_take_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_valid && pkt_ready) |=> !s1_vld);

  // R3
  fail_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(s1_vld));
endmodule

bind scan_resp_checker scmp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pkt_valid (pkt_valid),
  .pkt_ready (pkt_ready),
  .clr       (clr_cmd),
  .s1_vld    (s1_vld),
  .fail      (fail_q),
  .cnt       (cnt_q)
);

// File: tb/scan_resp_checker_tb.sv
module scan_resp_checker_tb;
  localparam int LANES = 16;
  localparam logic [15:0] KEY = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_valid = 1'b0;
  logic pkt_ready;
  logic [LANES-1:0] pkt_expect = '0, pkt_care = '0, scan_resp = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_rd_en = 1'b0, reg_wr_en = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  always #4 clk = ~clk;

  scan_resp_checker u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_expect(pkt_expect), .pkt_care(pkt_care), .scan_resp(scan_resp),
    .reg_addr(reg_addr), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  typedef struct {
    bit             clr;
    bit [LANES-1:0] vec;
  } item_t;

  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // reference summary
  bit             m_fail = 1'b0;
  int             m_cnt = 0;
  bit [LANES-1:0] m_lanes = '0;

  // monitor: applies expected items as the design consumes them
  always @(posedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.clr) begin
        m_fail = 1'b0; m_cnt = 0; m_lanes = '0;
      end else if (it.vec != '0) begin
        m_fail = 1'b1;
        if (m_cnt < 65535) m_cnt++;
        m_lanes |= it.vec;
      end
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      pkt_valid = 1'b0;
    end
  endtask

  // driver: presents a word, waits for the handshake, pushes the expected item
  task automatic send_word(logic [15:0] e, logic [15:0] c, logic [15:0] a);
    bit acc;
    item_t it;
    @(negedge clk);
    pkt_valid = 1'b1; pkt_expect = e; pkt_care = c; scan_resp = a;
    acc = 1'b0;
    while (!acc) begin
      @(posedge clk);
      acc = pkt_ready;
    end
    it.clr = 1'b0; it.vec = c & (e ^ a);
    q.push_back(it);
  endtask

  task automatic reg_write(logic [1:0] ad, logic [15:0] d);
    item_t it;
    @(negedge clk);
    pkt_valid = 1'b0;
    reg_wr_en = 1'b1; reg_addr = ad; reg_wdata = d;
    @(posedge clk);
    if (ad == 2'd3 && d == KEY) begin
      it.clr = 1'b1; it.vec = '0;
      q.push_back(it);
    end
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic read_chk(logic [1:0] ad, logic [15:0] exp, string req);
    @(negedge clk);
    pkt_valid = 1'b0;
    reg_rd_en = 1'b1; reg_addr = ad;
    @(negedge clk);
    reg_rd_en = 1'b0;
    check(req, reg_rdata, exp);
  endtask

  task automatic read_all(string req);
    idle(3);
    read_chk(2'd0, {14'd0, (m_cnt == 65535), m_fail}, req);
    read_chk(2'd1, 16'(m_cnt), req);
    read_chk(2'd2, m_lanes, req);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 ready", {15'd0, pkt_ready}, 16'd1);
    read_all("R9 reset");

    // R1 differences only on don't-care channels
    send_word(16'h00F0, 16'hFF0F, 16'h0000);
    send_word(16'hAAAA, 16'h0000, 16'h5555);
    read_all("R1 masked");

    // R2 mismatching data while valid is low
    @(negedge clk);
    pkt_valid = 1'b0; pkt_expect = 16'hFFFF; pkt_care = 16'hFFFF; scan_resp = 16'h0000;
    idle(4);
    read_all("R2 no valid");

    // R4 three channels wrong in one word counts once; R6 lane mask
    send_word(16'h0013, 16'h00FF, 16'h0000);
    read_all("R4 one per word");

    // R3 sticky through passing words
    send_word(16'h1234, 16'hFFFF, 16'h1234);
    send_word(16'h0000, 16'h0000, 16'hFFFF);
    read_all("R3 sticky");

    // R11 non-key writes and writes elsewhere
    reg_write(2'd3, 16'h0001);
    reg_write(2'd3, 16'hA5C2);
    reg_write(2'd0, KEY);
    read_all("R11 ignored");

    // R6 lanes accumulate by OR
    send_word(16'h8000, 16'h8000, 16'h0000);
    send_word(16'h0400, 16'h0C00, 16'h0800);
    read_all("R6 lanes");

    // R7 clear
    reg_write(2'd3, KEY);
    read_all("R7 clear");

    // R8 back-pressure during clear, word held and later accepted
    send_word(16'h0001, 16'h0001, 16'h0000);
    idle(2);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_expect = 16'h0002; pkt_care = 16'h0002; scan_resp = 16'h0000;
    reg_wr_en = 1'b1; reg_addr = 2'd3; reg_wdata = KEY;
    #1 check("R8 ready low", {15'd0, pkt_ready}, 16'd0);
    @(posedge clk);
    begin item_t it; it.clr = 1'b1; it.vec = '0; q.push_back(it); end
    @(negedge clk);
    reg_wr_en = 1'b0;
    #1 check("R8 ready back", {15'd0, pkt_ready}, 16'd1);
    @(posedge clk);
    begin item_t it; it.clr = 1'b0; it.vec = 16'h0002; q.push_back(it); end
    read_all("R8 held word");
    check("R8 count", 16'(m_cnt), 16'd1);

    // R7 word accepted just before clear is discarded
    send_word(16'h0100, 16'h0100, 16'h0000);
    reg_write(2'd3, KEY);
    read_all("R7 in-flight");
    check("R7 model", 16'(m_cnt), 16'd0);

    // R10 address 3 reads zero, rdata holds without a read
    send_word(16'h0004, 16'h0004, 16'h0000);
    idle(3);
    read_chk(2'd1, 16'd1, "R10 latency");
    idle(2);
    check("R10 hold", reg_rdata, 16'd1);
    read_chk(2'd3, 16'd0, "R10 ctrl read");

    // R5 saturation
    for (int i = 0; i < 65540; i++) send_word(16'hFFFF, 16'h0001, 16'h0000);
    read_all("R5 saturate");
    check("R5 model", 16'(m_cnt), 16'hFFFF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule